// File: doc/BRIEF.md
# Single-Beat PCI Master Sequencer

This block turns one host request into one non-burst transaction on a 32-bit PCI bus. The request comes from an upstream address decoder and carries the address, the bus command, the byte enables, the write data and a flag that marks a configuration cycle. The block shows FRAME# with the address and command and holds it until a target claims the cycle with DEVSEL#. It then drops FRAME#, raises IRDY# with the byte enables, and waits for the target's answer.

Each transaction ends with exactly one one-clock pulse to the host side: an acknowledge, an error acknowledge or an address retry. An acknowledged read also presents its 32-bit data word. When no target claims a configuration cycle, the block completes it quietly: a read returns all ones and a write simply finishes. Two counters bound the waits. One gives up on the claim after a set number of clocks. The other gives up on target ready after a set number of clocks in the data phase, a count sized for roughly 60 µs. Every termination is followed by one idle turnaround clock before the next request can be taken.

Top module: `pci_sb_master`

## Requirements
- R1: After reset FRAME# and IRDY# are high, the AD bus is not driven, C/BE# is all ones, no host response pulse is present and req_ready is high.
- R2: On the clock after a request is accepted, FRAME# is low, IRDY# is high, AD carries the request address with its driver on, and C/BE# carries the request command.
- R3: On the clock after DEVSEL# is sampled low with STOP# high during the address phase, FRAME# is high and IRDY# is low. C/BE# then carries the request byte enables. The AD driver is on only for writes, and for a write AD carries the write data.
- R4: A data-phase clock with DEVSEL# and TRDY# both low produces an acknowledge pulse on the next clock. For a read, host_rdata then equals the AD value sampled on that clock.
- R5: If DEVSEL# stays high for MA_CLKS address-phase clocks on a non-configuration request, the block ends with an error acknowledge. With the default of 5, a claim on the fifth clock still succeeds.
- R6: If the same master abort happens on a configuration request, the block ends with an acknowledge. For a read, host_rdata is 32'hFFFF_FFFF.
- R7: If TRDY# is not sampled low within TO_CLKS data-phase clocks, the block ends with an error acknowledge. A TRDY# on the last of those clocks still succeeds.
- R8: A data-phase clock with STOP# low and DEVSEL# high (target abort) ends with an error acknowledge.
- R9: A clock with DEVSEL# and STOP# both low and TRDY# high ends with an address-retry pulse and no acknowledge. This holds in the address phase and in the data phase.
- R10: While a response pulse is shown, FRAME# and IRDY# are high, the AD driver is off and req_ready is low. req_ready returns high on the next clock.
- R11: Each accepted request yields exactly one response pulse, and at most one of ack, error and retry is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle; a request is taken on this clock |
| req_addr | input | ADW | Remapped PCI address |
| req_cmd | input | CBW | PCI bus command for the address phase |
| req_be_n | input | CBW | Active-low byte enables for the data phase |
| req_wdata | input | ADW | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cfg | input | 1 | Request is a configuration cycle |
| host_ack | output | 1 | Transfer acknowledge pulse |
| host_err | output | 1 | Transfer error acknowledge pulse |
| host_retry | output | 1 | Address retry pulse |
| host_rdata | output | ADW | Read data, valid with host_ack |
| pci_ad_out | output | ADW | AD bus value driven by the block |
| pci_ad_oe | output | 1 | AD output enable |
| pci_ad_in | input | ADW | AD bus value seen on the bus |
| pci_cbe_n | output | CBW | Command / byte enable lines |
| pci_frame_n | output | 1 | FRAME# |
| pci_irdy_n | output | 1 | IRDY# |
| pci_devsel_n | input | 1 | DEVSEL# |
| pci_trdy_n | input | 1 | TRDY# |
| pci_stop_n | input | 1 | STOP# |

## Verification
The assertions assume that the target side follows PCI signalling. DEVSEL#, TRDY# and STOP# are driven only while this master owns a transaction, and they are released once a response pulse appears. The assertions also assume that a request is offered only while req_ready is high. The bench models a single target that keys each of its answers to a clock count. It counts from FRAME# going low for the claim and from IRDY# going low for the data-phase reply. It drives nothing after the response pulse, and it drops req_valid on the clock after acceptance.

// File: rtl/pci_sb_pkg.sv
package pci_sb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_TURN
  } seq_state_t;

  typedef enum logic [1:0] {
    RES_ACK,
    RES_ERR,
    RES_RETRY
  } result_t;
endpackage

// File: rtl/pci_sb_timer.sv
module pci_sb_timer #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en && !done) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5 / R7: the wait counter never runs past its limit
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/pci_sb_resp.sv
module pci_sb_resp
  import pci_sb_pkg::*;
#(
  parameter int ADW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fire,
  input  result_t        kind,
  input  logic [ADW-1:0] value,
  output logic           ack,
  output logic           err,
  output logic           retry,
  output logic [ADW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      err   <= 1'b0;
      retry <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= fire && (kind == RES_ACK);
      err   <= fire && (kind == RES_ERR);
      retry <= fire && (kind == RES_RETRY);
      if (fire && kind == RES_ACK) rdata <= value;
    end
  end

  // R11: at most one response kind per clock
  a_r11_one_response: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack, err, retry}));

  // R11: a pulse lasts one clock only
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (ack || err || retry) |=> !(ack || err || retry));
endmodule

// File: rtl/pci_sb_master.sv
module pci_sb_master
  import pci_sb_pkg::*;
#(
  parameter int ADW     = 32,
  parameter int MA_CLKS = 5,
  parameter int TO_CLKS = 2000,
  localparam int CBW    = ADW / 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [ADW-1:0] req_addr,
  input  logic [CBW-1:0] req_cmd,
  input  logic [CBW-1:0] req_be_n,
  input  logic [ADW-1:0] req_wdata,
  input  logic           req_write,
  input  logic           req_cfg,
  output logic           host_ack,
  output logic           host_err,
  output logic           host_retry,
  output logic [ADW-1:0] host_rdata,
  output logic [ADW-1:0] pci_ad_out,
  output logic           pci_ad_oe,
  input  logic [ADW-1:0] pci_ad_in,
  output logic [CBW-1:0] pci_cbe_n,
  output logic           pci_frame_n,
  output logic           pci_irdy_n,
  input  logic           pci_devsel_n,
  input  logic           pci_trdy_n,
  input  logic           pci_stop_n
);
  seq_state_t     st;
  logic [CBW-1:0] keep_be_n;
  logic [ADW-1:0] keep_wdata;
  logic           keep_write;
  logic           keep_cfg;

  logic           ma_done, to_done;
  logic           fin;
  result_t        fin_kind;
  logic [ADW-1:0] fin_value;

  assign req_ready = (st == ST_IDLE);

  pci_sb_timer #(.LIMIT(MA_CLKS)) u_claim_tmr (
    .clk (clk),
    .rst (rst),
    .clr (st != ST_ADDR),
    .en  (st == ST_ADDR && pci_devsel_n),
    .done(ma_done)
  );

  pci_sb_timer #(.LIMIT(TO_CLKS)) u_ready_tmr (
    .clk (clk),
    .rst (rst),
    .clr (st != ST_DATA),
    .en  (st == ST_DATA),
    .done(to_done)
  );

  // Termination decode; priority: data, retry, target abort, timeout
  always_comb begin
    fin       = 1'b0;
    fin_kind  = RES_ACK;
    fin_value = pci_ad_in;
    unique case (st)
      ST_ADDR: begin
        if (!pci_devsel_n && !pci_stop_n) begin
          fin      = 1'b1;
          fin_kind = RES_RETRY;
        end else if (pci_devsel_n && ma_done) begin
          fin       = 1'b1;
          fin_kind  = keep_cfg ? RES_ACK : RES_ERR;
          fin_value = '1;
        end
      end
      ST_DATA: begin
        if (!pci_devsel_n && !pci_trdy_n) begin
          fin = 1'b1;
        end else if (!pci_devsel_n && !pci_stop_n) begin
          fin      = 1'b1;
          fin_kind = RES_RETRY;
        end else if (pci_devsel_n && !pci_stop_n) begin
          fin      = 1'b1;
          fin_kind = RES_ERR;
        end else if (to_done) begin
          fin      = 1'b1;
          fin_kind = RES_ERR;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      pci_frame_n <= 1'b1;
      pci_irdy_n  <= 1'b1;
      pci_ad_oe   <= 1'b0;
      pci_ad_out  <= '0;
      pci_cbe_n   <= '1;
      keep_be_n   <= '1;
      keep_wdata  <= '0;
      keep_write  <= 1'b0;
      keep_cfg    <= 1'b0;
    end else if (fin) begin
      st          <= ST_TURN;
      pci_frame_n <= 1'b1;
      pci_irdy_n  <= 1'b1;
      pci_ad_oe   <= 1'b0;
      pci_cbe_n   <= '1;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          st          <= ST_ADDR;
          pci_frame_n <= 1'b0;
          pci_ad_oe   <= 1'b1;
          pci_ad_out  <= req_addr;
          pci_cbe_n   <= req_cmd;
          keep_be_n   <= req_be_n;
          keep_wdata  <= req_wdata;
          keep_write  <= req_write;
          keep_cfg    <= req_cfg;
        end
        ST_ADDR: if (!pci_devsel_n) begin
          st          <= ST_DATA;
          pci_frame_n <= 1'b1;
          pci_irdy_n  <= 1'b0;
          pci_cbe_n   <= keep_be_n;
          pci_ad_out  <= keep_wdata;
          pci_ad_oe   <= keep_write;
        end
        ST_DATA: ;
        ST_TURN: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  pci_sb_resp #(.ADW(ADW)) u_resp (
    .clk  (clk),
    .rst  (rst),
    .fire (fin),
    .kind (fin_kind),
    .value(fin_value),
    .ack  (host_ack),
    .err  (host_err),
    .retry(host_retry),
    .rdata(host_rdata)
  );

  a_r2_addr_phase: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid) |=> (!pci_frame_n && pci_irdy_n && pci_ad_oe));

  a_r3_data_entry: assert property (@(posedge clk) disable iff (rst)
    (!pci_frame_n && !pci_devsel_n && pci_stop_n) |=> (pci_frame_n && !pci_irdy_n));

  a_r4_ack_on_trdy: assert property (@(posedge clk) disable iff (rst)
    (!pci_irdy_n && !pci_devsel_n && !pci_trdy_n) |=> host_ack);

  a_r8_target_abort: assert property (@(posedge clk) disable iff (rst)
    (!pci_irdy_n && pci_devsel_n && !pci_stop_n) |=> host_err);

  a_r9_retry: assert property (@(posedge clk) disable iff (rst)
    ((!pci_irdy_n || !pci_frame_n) && !pci_devsel_n && !pci_stop_n && pci_trdy_n)
      |=> (host_retry && !host_ack));

  a_r10_idle_bus: assert property (@(posedge clk) disable iff (rst)
    (host_ack || host_err || host_retry)
      |-> (pci_frame_n && pci_irdy_n && !pci_ad_oe && !req_ready));

  a_r10_ready_back: assert property (@(posedge clk) disable iff (rst)
    (host_ack || host_err || host_retry) |=> req_ready);
endmodule

// File: tb/pci_sb_master_tb.sv
module pci_sb_master_tb;
  localparam int ADW = 32;
  localparam int CBW = 4;
  localparam int MA  = 5;
  localparam int TO  = 16;
  localparam int K_ACK = 0, K_ERR = 1, K_RETRY = 2;
  // target behaviours
  localparam int T_NORMAL = 0, T_ADDR_RETRY = 1, T_ABORT = 2, T_DATA_RETRY = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADW-1:0] req_addr = '0;
  logic [CBW-1:0] req_cmd = '0;
  logic [CBW-1:0] req_be_n = '1;
  logic [ADW-1:0] req_wdata = '0;
  logic req_write = 1'b0;
  logic req_cfg = 1'b0;
  logic host_ack, host_err, host_retry;
  logic [ADW-1:0] host_rdata;
  logic [ADW-1:0] pci_ad_out;
  logic pci_ad_oe;
  logic [ADW-1:0] pci_ad_in = '0;
  logic [CBW-1:0] pci_cbe_n;
  logic pci_frame_n, pci_irdy_n;
  logic pci_devsel_n = 1'b1;
  logic pci_trdy_n = 1'b1;
  logic pci_stop_n = 1'b1;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  int          q_kind[$];
  logic [31:0] q_data[$];
  logic        q_rd[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  pci_sb_master #(.ADW(ADW), .MA_CLKS(MA), .TO_CLKS(TO)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cmd(req_cmd), .req_be_n(req_be_n),
    .req_wdata(req_wdata), .req_write(req_write), .req_cfg(req_cfg),
    .host_ack(host_ack), .host_err(host_err), .host_retry(host_retry),
    .host_rdata(host_rdata),
    .pci_ad_out(pci_ad_out), .pci_ad_oe(pci_ad_oe), .pci_ad_in(pci_ad_in),
    .pci_cbe_n(pci_cbe_n), .pci_frame_n(pci_frame_n), .pci_irdy_n(pci_irdy_n),
    .pci_devsel_n(pci_devsel_n), .pci_trdy_n(pci_trdy_n), .pci_stop_n(pci_stop_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int kind_of(input logic a, input logic e, input logic r);
    if (a) return K_ACK;
    if (e) return K_ERR;
    return K_RETRY;
  endfunction

  // Scoreboard monitor: compares every response pulse with the queue head
  always @(negedge clk) begin
    if (!rst && (host_ack || host_err || host_retry)) begin
      if (q_kind.size() == 0) begin
        chk(1'b0, "R11 unexpected response", 64'(kind_of(host_ack, host_err, host_retry)), 64'd99);
      end else begin
        int          ek;
        logic [31:0] ed;
        logic        erd;
        string       tg;
        ek = q_kind.pop_front();
        ed = q_data.pop_front();
        erd = q_rd.pop_front();
        tg = q_tag.pop_front();
        chk(32'(host_ack) + 32'(host_err) + 32'(host_retry) == 1,
            {tg, " R11 one pulse"}, {61'd0, host_ack, host_err, host_retry}, 64'd1);
        chk(kind_of(host_ack, host_err, host_retry) == ek, {tg, " kind"},
            64'(kind_of(host_ack, host_err, host_retry)), 64'(ek));
        if (erd && ek == K_ACK)
          chk(host_rdata == ed, {tg, " rdata"}, 64'(host_rdata), 64'(ed));
      end
    end
  end

  // Driver plus target model for one transaction
  task automatic do_txn(input logic [31:0] addr, input logic [3:0] cmd,
                        input logic [3:0] be, input logic [31:0] wd,
                        input logic wr, input logic cfg,
                        input int dsel, input int tmode, input int tdly,
                        input logic [31:0] rd, input int ek,
                        input logic [31:0] ed, input string tag);
    int  k;
    int  j;
    bit  done;
    bit  seen_addr;
    bit  seen_data;
    q_kind.push_back(ek);
    q_data.push_back(ed);
    q_rd.push_back(!wr);
    q_tag.push_back(tag);
    @(negedge clk);
    req_addr  = addr;
    req_cmd   = cmd;
    req_be_n  = be;
    req_wdata = wd;
    req_write = wr;
    req_cfg   = cfg;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    j = -1;
    done = 0;
    seen_addr = 0;
    seen_data = 0;
    pci_ad_in = rd;
    while (!done) begin
      if (host_ack || host_err || host_retry) begin
        // R10: bus released while the pulse is shown
        chk(pci_frame_n && pci_irdy_n && !pci_ad_oe && !req_ready, {tag, " R10 turnaround"},
            {60'd0, pci_frame_n, pci_irdy_n, pci_ad_oe, req_ready}, 64'hC);
        pci_devsel_n = 1'b1;
        pci_trdy_n   = 1'b1;
        pci_stop_n   = 1'b1;
        done = 1;
      end else begin
        if (!seen_addr) begin
          seen_addr = 1;
          // R2: address phase contents
          chk(!pci_frame_n && pci_irdy_n && pci_ad_oe && pci_ad_out == addr && pci_cbe_n == cmd,
              {tag, " R2 addr phase"}, {pci_ad_out, 28'd0, pci_cbe_n}, {addr, 28'd0, cmd});
        end
        if (!pci_irdy_n && !seen_data) begin
          seen_data = 1;
          // R3: data phase contents
          chk(pci_frame_n && pci_cbe_n == be && pci_ad_oe == wr && (!wr || pci_ad_out == wd),
              {tag, " R3 data phase"}, {pci_ad_out, 27'd0, pci_ad_oe, pci_cbe_n},
              {wr ? wd : pci_ad_out, 27'd0, wr, be});
        end
        if (!pci_irdy_n) j++;
        pci_devsel_n = !(dsel >= 0 && k >= dsel);
        pci_trdy_n   = 1'b1;
        pci_stop_n   = 1'b1;
        if (tmode == T_ADDR_RETRY && !pci_devsel_n) pci_stop_n = 1'b0;
        if (j >= 0 && tdly >= 0 && j >= tdly) begin
          case (tmode)
            T_NORMAL:     pci_trdy_n = 1'b0;
            T_ABORT:      begin pci_devsel_n = 1'b1; pci_stop_n = 1'b0; end
            T_DATA_RETRY: pci_stop_n = 1'b0;
            default: ;
          endcase
        end
        k++;
      end
      @(negedge clk);
    end
    // R10: ready again one clock after the pulse
    chk(req_ready == 1'b1, {tag, " R10 ready back"}, 64'(req_ready), 64'd1);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=<50000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(pci_frame_n && pci_irdy_n && !pci_ad_oe && pci_cbe_n == 4'hF && req_ready &&
        !host_ack && !host_err && !host_retry, "R1 reset state",
        {56'd0, pci_frame_n, pci_irdy_n, pci_ad_oe, req_ready, pci_cbe_n}, 64'hDF);

    // R4 read / write with data
    do_txn(32'h0000_1000, 4'h6, 4'h0, 32'h0, 1'b0, 1'b0, 1, T_NORMAL, 2,
           32'hCAFE_0001, K_ACK, 32'hCAFE_0001, "R4 mem read");
    do_txn(32'h0000_2004, 4'h7, 4'hC, 32'h1234_5678, 1'b1, 1'b0, 0, T_NORMAL, 0,
           32'h0, K_ACK, 32'h0, "R4 mem write");
    do_txn(32'h0000_0CF8, 4'h2, 4'hE, 32'h0, 1'b0, 1'b0, 3, T_NORMAL, 4,
           32'h0000_00A5, K_ACK, 32'h0000_00A5, "R4 io read");
    // R5 master abort and its boundary
    do_txn(32'h0100_0000, 4'h6, 4'h0, 32'h0, 1'b0, 1'b0, -1, T_NORMAL, 0,
           32'h0, K_ERR, 32'h0, "R5 master abort");
    do_txn(32'h0100_0004, 4'h6, 4'h0, 32'h0, 1'b0, 1'b0, MA, T_NORMAL, 0,
           32'h0, K_ERR, 32'h0, "R5 claim too late");
    do_txn(32'h0100_0008, 4'h6, 4'h0, 32'h0, 1'b0, 1'b0, MA - 1, T_NORMAL, 0,
           32'h5555_AAAA, K_ACK, 32'h5555_AAAA, "R5 claim last clock");
    // R6 configuration master abort
    do_txn(32'h0000_0800, 4'hA, 4'h0, 32'h0, 1'b0, 1'b1, -1, T_NORMAL, 0,
           32'h1111_2222, K_ACK, 32'hFFFF_FFFF, "R6 cfg read");
    do_txn(32'h0000_0804, 4'hB, 4'h0, 32'h9, 1'b1, 1'b1, -1, T_NORMAL, 0,
           32'h0, K_ACK, 32'h0, "R6 cfg write");
    // R7 timeout and its boundary
    do_txn(32'h0200_0000, 4'h6, 4'h0, 32'h0, 1'b0, 1'b0, 1, T_NORMAL, -1,
           32'h0, K_ERR, 32'h0, "R7 timeout");
    do_txn(32'h0200_0004, 4'h6, 4'h0, 32'h0, 1'b0, 1'b0, 1, T_NORMAL, TO - 1,
           32'h0BAD_F00D, K_ACK, 32'h0BAD_F00D, "R7 trdy last clock");
    // R8 target abort
    do_txn(32'h0300_0000, 4'h7, 4'h3, 32'hDEAD_BEEF, 1'b1, 1'b0, 2, T_ABORT, 1,
           32'h0, K_ERR, 32'h0, "R8 target abort");
    // R9 retry in both phases
    do_txn(32'h0400_0000, 4'h6, 4'h0, 32'h0, 1'b0, 1'b0, 1, T_DATA_RETRY, 2,
           32'h0, K_RETRY, 32'h0, "R9 data retry");
    do_txn(32'h0400_0004, 4'h7, 4'h0, 32'h7, 1'b1, 1'b0, 2, T_ADDR_RETRY, 0,
           32'h0, K_RETRY, 32'h0, "R9 addr retry");
    // back to back after retry
    do_txn(32'h0000_3000, 4'h6, 4'h8, 32'h0, 1'b0, 1'b0, 0, T_NORMAL, 0,
           32'h0000_7777, K_ACK, 32'h0000_7777, "R4 after retry");

    repeat (3) @(negedge clk);
    // R11: every request answered exactly once
    chk(q_kind.size() == 0, "R11 queue drained", 64'(q_kind.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule